// File: doc/BRIEF.md
# Macroblock Coding Mode Decision

This block settles, once per 16x16 luminance macroblock, two choices that a video encoder makes before transforming the data. The first is whether motion compensation pays off. The second is whether the macroblock is coded predictively (inter) or on its own (intra). The 256 luminance pixels stream in one per accepted cycle and are kept in a local buffer. On the cycle that takes the last pixel, the block also samples the motion search results and the frame-level and macroblock-level control levels. These are the best-fit matching error with its displacement, the zero-displacement error, and the override and refresh controls.

After the last pixel the block makes a second pass over the buffer. This pass measures how far each pixel sits from the macroblock mean, which gives a cheap activity figure. The block then weighs that figure against the matching error that the motion compensation rule selected. A periodic refresh counter forces intra coding on a fixed cadence so that prediction drift cannot build up. Explicit overrides from the host are applied on top in a fixed priority order. The result is presented with a single-cycle done pulse and held until the next macroblock completes.

Top module: `mb_mode_decide`

## Requirements
- R1: `mc_on` is 1 exactly when 8 x `err_zero` > 9 x `err_best`, computed without rounding, and `mc_disable` is low. When `mc_on` is 1, `mv_h`/`mv_v` equal the sampled best displacement and the best-fit error is the selected error. Otherwise both vector outputs are 0 and the zero-displacement error is selected.
- R2: `variance` equals the sum over all 256 pixels of |pixel - mean|, shifted right by 2. Here mean = (sum of pixels) >> 8.
- R3: If bits [13:6] of the selected error are below the 8-bit threshold, the internal decision is inter (`intra`=0). The threshold is 3 after reset and takes `thr_wdata` on any cycle with `thr_we` high.
- R4: If bits [13:6] of the selected error are at or above the threshold, the internal decision is inter only when `variance` >= the selected error, and intra otherwise.
- R5: A refresh counter counts the decided macroblocks that are not frozen. Every 61st of these is refreshed, meaning the counter goes 0..60 and the macroblock decided with the count at 60 is refreshed. A refreshed macroblock is intra unless a higher-priority source decides otherwise.
- R6: While any of `fix_mb`, `skip_frame` or `own_refresh` is sampled high, the counter neither advances nor refreshes.
- R7: The priority for `intra` runs from highest to lowest as follows. First, `fast_update` forces 1. Next, `ovr_en` forces the value of `ovr_intra`, so a forced inter beats a refresh. Then a refresh forces 1. Finally, the internal decision of R3/R4 applies.
- R8: With `mc_disable` high, `mc_on` is 0, the vector outputs are 0 and the zero-displacement error is used.
- R9: `done` is high for exactly one cycle, on the 258th clock edge after the edge that captured the last pixel. All result outputs change only on that edge.
- R10: Pixels presented from the edge after the last pixel through the decision edge are ignored. They neither alter the result nor count toward the next macroblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 8 | Luminance pixel |
| err_best | input | 14 | Best-fit matching error, sampled with the last pixel |
| err_zero | input | 14 | Zero-displacement error, sampled with the last pixel |
| mv_best_h | input | 5 | Best-fit horizontal displacement, two's complement |
| mv_best_v | input | 5 | Best-fit vertical displacement, two's complement |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold write value |
| fix_mb | input | 1 | Fixed-macroblock level, freezes refresh |
| skip_frame | input | 1 | Skipped-frame level, freezes refresh |
| fast_update | input | 1 | Whole-frame intra level |
| ovr_en | input | 1 | Host override of the inter/intra choice |
| ovr_intra | input | 1 | Override value, 1 = intra |
| own_refresh | input | 1 | Host runs its own refresh policy, freezes the counter |
| mc_disable | input | 1 | Turns motion compensation off |
| done | output | 1 | One-cycle result strobe |
| mc_on | output | 1 | Motion compensation applied |
| intra | output | 1 | 1 = intra, 0 = inter |
| mv_h | output | 5 | Chosen horizontal vector |
| mv_v | output | 5 | Chosen vertical vector |
| variance | output | 14 | Mean-deviation activity of the macroblock |

## Verification
The assertions take two things for granted about the inputs. First, the error, vector and control inputs are meaningful only on the cycle that carries the last pixel. Second, the host changes those controls only between macroblocks. The checks therefore relate the outputs at `done` to the control state the block sampled, and not to the live pins. The stimulus follows the same rule: it sets every control and error value before the first pixel of a macroblock and leaves it unchanged until that macroblock's result has been read. The only activity between macroblocks is the deliberate pixel noise used for R10 and the threshold writes used for R3.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    localparam int PIX_W          = 8;
    localparam int REFRESH_PERIOD = 61;
    localparam logic [7:0] THR_RESET = 8'd3;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_DECIDE = 2'd2
    } mbd_state_t;

    // control levels sampled together with the last pixel
    typedef struct packed {
        logic fix_mb;
        logic skip_frm;
        logic fast_upd;
        logic ovr_en;
        logic ovr_intra;
        logic own_ref;
        logic mc_dis;
    } mbd_ctl_t;

    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                  input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/mbd_pix_buffer.sv
module mbd_pix_buffer #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/mbd_refresh.sv
module mbd_refresh #(
    parameter int PERIOD = 61,
    localparam int CW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          freeze,
    output logic          fire,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    assign fire = !freeze && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step && !freeze) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mbd_select.sv
module mbd_select
    import mbd_pkg::*;
#(
    parameter int EW   = 14,
    parameter int MVW  = 5,
    parameter int VARW = 14
) (
    input  logic [EW-1:0]   err_best,
    input  logic [EW-1:0]   err_zero,
    input  logic [MVW-1:0]  mv_in_h,
    input  logic [MVW-1:0]  mv_in_v,
    input  logic [VARW-1:0] var_in,
    input  logic [7:0]      thr,
    input  mbd_ctl_t        ctl,
    input  logic            refresh_fire,
    output logic            mc_on,
    output logic            intra,
    output logic [MVW-1:0]  mv_h,
    output logic [MVW-1:0]  mv_v
);

    logic [EW+3:0] zero_x8;
    logic [EW+3:0] best_x9;
    logic [EW-1:0] sel_err;
    logic          internal_intra;

    always_comb begin
        zero_x8 = {1'b0, err_zero, 3'b000};
        best_x9 = {4'b0000, err_best} + {1'b0, err_best, 3'b000};
        mc_on   = !ctl.mc_dis && (zero_x8 > best_x9);
        sel_err = mc_on ? err_best : err_zero;
        mv_h    = mc_on ? mv_in_h : '0;
        mv_v    = mc_on ? mv_in_v : '0;

        internal_intra = (sel_err[EW-1 -: 8] >= thr) &&
                         (32'(var_in) < 32'(sel_err));

        if (ctl.fast_upd) begin
            intra = 1'b1;
        end else if (ctl.ovr_en) begin
            intra = ctl.ovr_intra;
        end else if (refresh_fire) begin
            intra = 1'b1;
        end else begin
            intra = internal_intra;
        end
    end

endmodule

// File: rtl/mb_mode_decide.sv
module mb_mode_decide
    import mbd_pkg::*;
#(
    parameter int NPIX    = 256,
    parameter int EW      = 14,
    parameter int MVW     = 5,
    parameter int REFRESH = REFRESH_PERIOD,
    localparam int AW     = $clog2(NPIX),
    localparam int SUMW   = PIX_W + AW,
    localparam int VARW   = SUMW - 2,
    localparam int RCW    = $clog2(REFRESH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic [7:0]       pix_data,
    input  logic [EW-1:0]    err_best,
    input  logic [EW-1:0]    err_zero,
    input  logic [MVW-1:0]   mv_best_h,
    input  logic [MVW-1:0]   mv_best_v,
    input  logic             thr_we,
    input  logic [7:0]       thr_wdata,
    input  logic             fix_mb,
    input  logic             skip_frame,
    input  logic             fast_update,
    input  logic             ovr_en,
    input  logic             ovr_intra,
    input  logic             own_refresh,
    input  logic             mc_disable,
    output logic             done,
    output logic             mc_on,
    output logic             intra,
    output logic [MVW-1:0]   mv_h,
    output logic [MVW-1:0]   mv_v,
    output logic [VARW-1:0]  variance
);

    localparam logic [AW-1:0] PIX_LAST = AW'(NPIX - 1);
    localparam logic [AW:0]   SCAN_END = (AW+1)'(NPIX);

    mbd_state_t      st;
    logic [AW-1:0]   pcnt;
    logic [AW:0]     scnt;
    logic [SUMW-1:0] sum;
    logic [SUMW-1:0] acc;
    logic            rdv;
    logic [7:0]      rdata;
    logic [7:0]      mean;
    logic [7:0]      thr_q;
    mbd_ctl_t        ctl_q;
    logic [EW-1:0]   eb_q, ez_q;
    logic [MVW-1:0]  mvh_q, mvv_q;
    logic            dec_step;
    logic            ref_fire;
    logic [RCW-1:0]  ref_cnt;
    logic            s_mc, s_intra;
    logic [MVW-1:0]  s_mvh, s_mvv;
    logic            buf_we, buf_re;

    assign mean     = sum[SUMW-1 -: 8];
    assign dec_step = (st == ST_DECIDE);
    assign buf_we   = (st == ST_FILL) && pix_valid;
    assign buf_re   = (st == ST_SCAN) && (scnt < SCAN_END);

    mbd_pix_buffer #(.DEPTH(NPIX), .DW(8)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (pcnt),
        .wdata (pix_data),
        .re    (buf_re),
        .raddr (scnt[AW-1:0]),
        .rdata (rdata)
    );

    mbd_refresh #(.PERIOD(REFRESH)) u_refresh (
        .clk    (clk),
        .rst    (rst),
        .step   (dec_step),
        .freeze (ctl_q.fix_mb | ctl_q.skip_frm | ctl_q.own_ref),
        .fire   (ref_fire),
        .cnt    (ref_cnt)
    );

    mbd_select #(.EW(EW), .MVW(MVW), .VARW(VARW)) u_select (
        .err_best     (eb_q),
        .err_zero     (ez_q),
        .mv_in_h      (mvh_q),
        .mv_in_v      (mvv_q),
        .var_in       (acc[SUMW-1:2]),
        .thr          (thr_q),
        .ctl          (ctl_q),
        .refresh_fire (ref_fire),
        .mc_on        (s_mc),
        .intra        (s_intra),
        .mv_h         (s_mvh),
        .mv_v         (s_mvv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_FILL;
            pcnt     <= '0;
            scnt     <= '0;
            sum      <= '0;
            acc      <= '0;
            rdv      <= 1'b0;
            thr_q    <= THR_RESET;
            ctl_q    <= '0;
            eb_q     <= '0;
            ez_q     <= '0;
            mvh_q    <= '0;
            mvv_q    <= '0;
            done     <= 1'b0;
            mc_on    <= 1'b0;
            intra    <= 1'b0;
            mv_h     <= '0;
            mv_v     <= '0;
            variance <= '0;
        end else begin
            done <= 1'b0;
            if (thr_we) begin
                thr_q <= thr_wdata;
            end
            case (st)
                ST_FILL: begin
                    if (pix_valid) begin
                        sum  <= (pcnt == '0) ? SUMW'(pix_data) : sum + SUMW'(pix_data);
                        pcnt <= pcnt + 1'b1;
                        if (pcnt == PIX_LAST) begin
                            st    <= ST_SCAN;
                            scnt  <= '0;
                            acc   <= '0;
                            rdv   <= 1'b0;
                            eb_q  <= err_best;
                            ez_q  <= err_zero;
                            mvh_q <= mv_best_h;
                            mvv_q <= mv_best_v;
                            ctl_q <= '{fix_mb: fix_mb, skip_frm: skip_frame,
                                       fast_upd: fast_update, ovr_en: ovr_en,
                                       ovr_intra: ovr_intra, own_ref: own_refresh,
                                       mc_dis: mc_disable};
                        end
                    end
                end
                ST_SCAN: begin
                    rdv <= (scnt < SCAN_END);
                    if (rdv) begin
                        acc <= acc + SUMW'(abs_diff(rdata, mean));
                    end
                    if (scnt == SCAN_END) begin
                        st <= ST_DECIDE;
                    end
                    scnt <= scnt + 1'b1;
                end
                ST_DECIDE: begin
                    mc_on    <= s_mc;
                    intra    <= s_intra;
                    mv_h     <= s_mvh;
                    mv_v     <= s_mvv;
                    variance <= acc[SUMW-1:2];
                    done     <= 1'b1;
                    pcnt     <= '0;
                    st       <= ST_FILL;
                end
                default: st <= ST_FILL;
            endcase
        end
    end

endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
    import mbd_pkg::*;
#(
    parameter int MVW     = 5,
    parameter int REFRESH = 61,
    localparam int RCW    = $clog2(REFRESH)
) (
    input logic           clk,
    input logic           rst,
    input logic           done,
    input logic           mc_on,
    input logic           intra,
    input logic [MVW-1:0] mv_h,
    input logic [MVW-1:0] mv_v,
    input mbd_ctl_t       ctl_q,
    input logic [RCW-1:0] ref_cnt,
    input logic           dec_step
);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_mv_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (done && !mc_on) |-> (mv_h == '0 && mv_v == '0));

    p_mc_off_r8: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_q.mc_dis) |-> (!mc_on && mv_h == '0 && mv_v == '0));

    p_fast_intra_r7: assert property (@(posedge clk) disable iff (rst)
        (done && ctl_q.fast_upd) |-> intra);

    p_ovr_value_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !ctl_q.fast_upd && ctl_q.ovr_en) |-> (intra == ctl_q.ovr_intra));

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(ref_cnt) < REFRESH));

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (dec_step && (ctl_q.fix_mb || ctl_q.skip_frm || ctl_q.own_ref)) |=> $stable(ref_cnt));

    p_done_after_step_r9: assert property (@(posedge clk) disable iff (rst)
        dec_step |=> done);

endmodule

bind mb_mode_decide mbd_checker #(.MVW(MVW), .REFRESH(REFRESH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .mc_on    (mc_on),
    .intra    (intra),
    .mv_h     (mv_h),
    .mv_v     (mv_v),
    .ctl_q    (ctl_q),
    .ref_cnt  (ref_cnt),
    .dec_step (dec_step)
);

// File: tb/mb_mode_decide_tb.sv
module mb_mode_decide_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic [13:0] err_best = '0, err_zero = '0;
    logic [4:0] mv_best_h = '0, mv_best_v = '0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wdata = '0;
    logic       fix_mb = 0, skip_frame = 0, fast_update = 0;
    logic       ovr_en = 0, ovr_intra = 0, own_refresh = 0, mc_disable = 0;
    logic       done, mc_on, intra;
    logic [4:0] mv_h, mv_v;
    logic [13:0] variance;

    int checks = 0;
    int fails  = 0;
    int thr_m  = 3;
    int cnt_m  = 0;
    bit finished = 0;
    int px [NPIX];

    always #(CLK_PERIOD/2) clk = ~clk;

    mb_mode_decide u_dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
        .err_best(err_best), .err_zero(err_zero),
        .mv_best_h(mv_best_h), .mv_best_v(mv_best_v),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .fix_mb(fix_mb), .skip_frame(skip_frame), .fast_update(fast_update),
        .ovr_en(ovr_en), .ovr_intra(ovr_intra), .own_refresh(own_refresh),
        .mc_disable(mc_disable),
        .done(done), .mc_on(mc_on), .intra(intra),
        .mv_h(mv_h), .mv_v(mv_v), .variance(variance)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_thr(input int v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_wdata = 8'(v);
        @(negedge clk);
        thr_we = 1'b0;
        thr_m = v;
    endtask

    // pat: 0 random, 1 constant, 2 ramp, 3 two-level, 4 narrow band
    // em: 0 random, 1 on 9/8 line, 2 one above line, 3 equal variance,
    //     4 variance+1, 5 tiny, 6 huge, 7 error 191, 8 error 192
    task automatic run_mb(input int pat, input int em, input bit noise);
        int sum, mean, dev, var_m, k, eb, ez, sel, mvh, mvv, base;
        bit mc_m, fire_m, int_intra, intra_m, frozen;
        base = int'($urandom % 256);
        sum = 0;
        for (int i = 0; i < NPIX; i++) begin
            case (pat)
                0: px[i] = int'($urandom % 256);
                1: px[i] = base;
                2: px[i] = (i + base) % 256;
                3: px[i] = (((i & 1) ^ ((i >> 4) & 1)) != 0) ? 255 : 0;
                default: px[i] = 100 + int'($urandom % 8);
            endcase
            sum += px[i];
        end
        mean = sum >> 8;
        dev = 0;
        for (int i = 0; i < NPIX; i++) begin
            dev += (px[i] > mean) ? px[i] - mean : mean - px[i];
        end
        var_m = dev >> 2;
        k = int'($urandom % 1821);
        case (em)
            0: begin eb = int'($urandom % 16384); ez = int'($urandom % 16384); end
            1: begin eb = 8 * k; ez = 9 * k; end
            2: begin eb = 8 * k; ez = 9 * k + 1; end
            3: begin eb = var_m; ez = var_m; end
            4: begin eb = (var_m < 16383) ? var_m + 1 : 16383; ez = eb; end
            5: begin eb = 0; ez = 0; end
            6: begin eb = 16383; ez = 16383; end
            7: begin eb = 191; ez = 191; end
            default: begin eb = 192; ez = 192; end
        endcase
        mvh = int'($urandom % 32);
        mvv = int'($urandom % 32);
        mc_m = !mc_disable && (ez * 8 > eb * 9);
        sel = mc_m ? eb : ez;
        int_intra = ((sel >> 6) >= thr_m) && (var_m < sel);
        frozen = fix_mb || skip_frame || own_refresh;
        fire_m = !frozen && (cnt_m == 60);
        if (!frozen) cnt_m = (cnt_m == 60) ? 0 : cnt_m + 1;
        if (fast_update) intra_m = 1;
        else if (ovr_en) intra_m = ovr_intra;
        else if (fire_m) intra_m = 1;
        else intra_m = int_intra;

        err_best = 14'(eb);
        err_zero = 14'(ez);
        mv_best_h = 5'(mvh);
        mv_best_v = 5'(mvv);
        for (int i = 0; i < NPIX; i++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_data = 8'(px[i]);
        end
        for (int c = 0; c < 260; c++) begin
            @(negedge clk);
            if (c < 258) begin
                pix_valid = noise;
                pix_data = 8'($urandom);
            end else begin
                pix_valid = 1'b0;
            end
            if (c == 257) chk(done == 1'b0, "R9", "done early", int'(done), 0);
            if (c == 258) begin
                chk(done == 1'b1, "R9", "done at edge 258", int'(done), 1);
                chk(mc_on == mc_m, mc_disable ? "R8" : "R1", "mc_on", int'(mc_on), int'(mc_m));
                chk(mv_h == (mc_m ? 5'(mvh) : 5'd0), "R1", "mv_h", int'(mv_h), mc_m ? mvh : 0);
                chk(mv_v == (mc_m ? 5'(mvv) : 5'd0), "R1", "mv_v", int'(mv_v), mc_m ? mvv : 0);
                chk(intra == intra_m,
                    fast_update || ovr_en ? "R7" : (fire_m ? "R5" : "R4"),
                    "intra", int'(intra), int'(intra_m));
                chk(int'(variance) == var_m, noise ? "R10" : "R2", "variance",
                    int'(variance), var_m);
            end
            if (c == 259) chk(done == 1'b0, "R9", "done single cycle", int'(done), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && mc_on == 0 && intra == 0 && variance == 0, "R9",
            "reset outputs", int'(done) + int'(mc_on) + int'(intra), 0);

        // R3: reset threshold 3, error 191 -> bits[13:6]=2 inter; 192 -> 3 intra
        run_mb(1, 7, 0);
        run_mb(1, 8, 0);

        // main sweep with refresh at the 61st macroblock (R5)
        for (int i = 3; i <= 64; i++) begin
            if (i == 60 || i == 61) run_mb(i % 5, 5, 0);
            else run_mb(i % 5, i % 5, 0);
        end

        // R6: frozen counter
        fix_mb = 1;      run_mb(0, 6, 0); run_mb(2, 5, 0); fix_mb = 0;
        skip_frame = 1;  run_mb(1, 5, 0); run_mb(3, 1, 0); skip_frame = 0;
        own_refresh = 1; run_mb(4, 2, 0); own_refresh = 0;

        // R7: fast update and user override
        fast_update = 1; run_mb(1, 5, 0); run_mb(0, 3, 0); fast_update = 0;
        ovr_en = 1; ovr_intra = 1; run_mb(1, 5, 0); run_mb(2, 2, 0);
        ovr_en = 0; ovr_intra = 0;

        for (int j = 0; j < 56; j++) begin
            mc_disable = (j < 4);
            if (j == 4) write_thr(0);
            if (j == 8) write_thr(255);
            if (j == 12) write_thr(3);
            if (cnt_m == 60) begin
                // R7: forced inter wins over refresh
                ovr_en = 1; ovr_intra = 0;
                run_mb(0, 6, 0);
                ovr_en = 0;
            end else if (j < 4) begin
                run_mb(j % 5, 2, 0);
            end else if (j >= 12 && j < 16) begin
                run_mb(j % 5, j % 5, 1);   // R10 noise between macroblocks
            end else begin
                run_mb(j % 5, (j * 7) % 7, 0);
            end
        end
        mc_disable = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule